// File: doc/BRIEF.md
# Sampling Converter Conversion and Serial Readout Sequencer

This block models the digital side of a 12-bit successive-approximation sampling converter. A host requests a conversion through an active-low start input. The block then raises a busy flag and times the conversion internally with a system-clock cycle counter. When the conversion ends, it captures the code from a parallel input that stands in for the analog core. A host reads that code through a serial output. The host supplies the serial clock, and the data line is released to high impedance whenever no read frame is in progress.

There are two operating modes. In fast mode, a falling edge on the start input begins the conversion and places the sampler in hold at once. In auto-sleep mode, a rising edge on the start input wakes the block. The sampler enters hold a fixed number of cycles later, the whole conversion takes longer, and the block goes back to sleep when it finishes. Every falling edge of the start input forces the output shift register back to its idle state, whatever the mode or the conversion state.

All durations are parameters given in system-clock cycles, so a bench can run scaled-down timings.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, busy_o, hold_o and sdata_oe_o are 0, and sleep_o equals mode_sleep_i.
- R2: In fast mode (mode_sleep_i=0), a falling edge of conv_n_i while idle raises busy_o and hold_o together one clock later. busy_o stays high for exactly FAST_CYC cycles.
- R3: In auto-sleep mode (mode_sleep_i=1), a rising edge of conv_n_i while idle raises busy_o one clock later and clears sleep_o. hold_o stays low for the first WAKE_CYC busy cycles and is high for the rest. busy_o lasts SLEEP_CYC cycles in total, and sleep_o returns to 1 afterwards.
- R4: busy_o and hold_o fall in the same cycle. The value on result_i in the last busy cycle becomes the stored result.
- R5: A read frame is 16 serial clocks. On each rising edge of sclk_i the next bit appears on sdata_o and sdata_oe_o is 1. The frame is four 0 bits followed by the 12-bit stored result, MSB first. The host samples on the falling edge.
- R6: On the falling edge of the 16th serial clock, sdata_oe_o returns to 0 and sdata_o is high impedance.
- R7: Serial clocks beyond the 16th are not blocked. The 17th rising edge starts a fresh frame, loaded from the stored result at that moment.
- R8: Every falling edge of conv_n_i, in either mode and whether busy or not, clears the shift register and sets sdata_oe_o to 0 one clock later. This clear wins over a serial clock edge in the same cycle, and the next rising edge restarts the frame at its first bit.
- R9: A start edge that arrives while busy_o is 1 does not restart or lengthen the conversion.
- R10: The result uses straight binary coding. The codes 0x000 and 0xFFF, and codes in between, are stored and shifted out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sleep_i | input | 1 | 0 selects fast mode, 1 selects auto-sleep mode |
| conv_n_i | input | 1 | Conversion start, active low |
| result_i | input | 12 | Code from the analog core |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_o | output | 1 | Serial data, high impedance when released |
| sdata_oe_o | output | 1 | Serial data line driven |
| busy_o | output | 1 | Conversion in progress |
| hold_o | output | 1 | Sampler in hold |
| sleep_o | output | 1 | Auto-sleep mode and idle |

## Verification
The main collision is a start falling edge and a serial clock rising edge in the same system cycle. When that happens, the frame clear and the next bit shift compete for the same register. The bench provokes it by driving both edges on one clock in the middle of a frame. It then expects the line to be released and the following read to begin again from the first padding bit. A second overlap is a host read that runs while a new conversion is completing. The bench reads during a conversion and expects the frame to carry the code stored before that conversion. The per-clock reference model compares every output in every cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W   = 12;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_HOLD
  } conv_st_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign rise_o = !sig_q && sig_i;
  assign fall_o = sig_q && !sig_i;
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer
  import sar_seq_pkg::*;
#(
  parameter int FAST_CYC  = 80,
  parameter int SLEEP_CYC = 140,
  parameter int WAKE_CYC  = 60,
  parameter int DW        = RES_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_fast_i,
  input  logic          start_sleep_i,
  input  logic [DW-1:0] result_i,
  output logic          busy_o,
  output logic          hold_o,
  output logic [DW-1:0] result_o
);
  localparam int MAX_CYC = (SLEEP_CYC > FAST_CYC) ? SLEEP_CYC : FAST_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] FAST_LAST  = TMR_W'(FAST_CYC - 1);
  localparam logic [TMR_W-1:0] SLEEP_LAST = TMR_W'(SLEEP_CYC - 1);
  localparam logic [TMR_W-1:0] WAKE_LAST  = TMR_W'(WAKE_CYC - 1);

  conv_st_e         st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] end_q;
  logic [DW-1:0]    res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      end_q <= '0;
      res_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (start_fast_i) begin
            st_q  <= ST_HOLD;
            end_q <= FAST_LAST;
          end else if (start_sleep_i) begin
            st_q  <= ST_WAKE;
            end_q <= SLEEP_LAST;
          end
        end
        ST_WAKE: begin
          tmr_q <= tmr_q + 1'b1;
          if (tmr_q == WAKE_LAST) st_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_q == end_q) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
            res_q <= result_i;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign hold_o   = (st_q == ST_HOLD);
  assign result_o = res_q;
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out
  import sar_seq_pkg::*;
#(
  parameter int DW = RES_W,
  parameter int FW = FRAME_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic [DW-1:0] result_i,
  output logic          sdata_o,
  output logic          oe_o
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW);

  logic [FW-1:0] sr_q;
  logic [CW-1:0] cnt_q;
  logic          bit_q;
  logic          oe_q;
  logic [FW-1:0] word;

  // padding bits lead, result MSB first
  assign word = FW'(result_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (sclk_rise_i) begin
      cnt_q <= cnt_q + 1'b1;
      oe_q  <= 1'b1;
      if (cnt_q == '0) begin
        bit_q <= word[FW-1];
        sr_q  <= word << 1;
      end else begin
        bit_q <= sr_q[FW-1];
        sr_q  <= sr_q << 1;
      end
    end else if (sclk_fall_i && cnt_q == LAST) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end
  end

  assign sdata_o = bit_q;
  assign oe_o    = oe_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int FAST_CYC  = 80,
  parameter int SLEEP_CYC = 140,
  parameter int WAKE_CYC  = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_sleep_i,
  input  logic             conv_n_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             sclk_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             busy_o,
  output logic             hold_o,
  output logic             sleep_o
);
  logic             conv_rise, conv_fall;
  logic             sclk_rise, sclk_fall;
  logic [RES_W-1:0] res_q;
  logic             bit_d;
  logic             oe_d;

  sar_edge_det #(.RST_VAL(1'b1)) u_conv_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (conv_n_i),
    .rise_o(conv_rise),
    .fall_o(conv_fall)
  );

  sar_edge_det #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sclk_i),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  sar_conv_timer #(
    .FAST_CYC (FAST_CYC),
    .SLEEP_CYC(SLEEP_CYC),
    .WAKE_CYC (WAKE_CYC),
    .DW       (RES_W)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_fast_i (conv_fall && !mode_sleep_i),
    .start_sleep_i(conv_rise && mode_sleep_i),
    .result_i     (result_i),
    .busy_o       (busy_o),
    .hold_o       (hold_o),
    .result_o     (res_q)
  );

  sar_shift_out #(
    .DW(RES_W),
    .FW(FRAME_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (conv_fall),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .result_i   (res_q),
    .sdata_o    (bit_d),
    .oe_o       (oe_d)
  );

  assign sdata_oe_o = oe_d;
  assign sdata_o    = oe_d ? bit_d : 1'bz;
  assign sleep_o    = mode_sleep_i && !busy_o;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int FAST_CYC  = 80,
  parameter int SLEEP_CYC = 140,
  parameter int WAKE_CYC  = 60
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_sleep_i,
  input logic conv_n_i,
  input logic busy_o,
  input logic hold_o,
  input logic sleep_o,
  input logic sdata_oe_o
);
  logic [31:0] run_q;
  logic        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      run_q <= busy_o ? run_q + 1 : '0;
      if (!busy_o) mode_q <= mode_sleep_i;
    end
  end

  // R2
  start_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mode_sleep_i && $past(conv_n_i) && !conv_n_i) |=> (busy_o && hold_o));

  // R3
  start_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && mode_sleep_i && !$past(conv_n_i) && conv_n_i) |=> (busy_o && !hold_o && !sleep_o));

  // R3
  wake_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_o) && mode_q) |-> (run_q == 32'(WAKE_CYC)));

  // R9
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == (mode_q ? 32'(SLEEP_CYC) : 32'(FAST_CYC))));

  // R8
  frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(conv_n_i) && !conv_n_i) |=> !sdata_oe_o);
endmodule

bind sar_seq_top sar_seq_chk #(
  .FAST_CYC (FAST_CYC),
  .SLEEP_CYC(SLEEP_CYC),
  .WAKE_CYC (WAKE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_sleep_i(mode_sleep_i),
  .conv_n_i    (conv_n_i),
  .busy_o      (busy_o),
  .hold_o      (hold_o),
  .sleep_o     (sleep_o),
  .sdata_oe_o  (sdata_oe_o)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FAST  = 10;
  localparam int SLEEP = 18;
  localparam int WAKE  = 7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_sleep_i = 1'b0;
  logic        conv_n_i = 1'b1;
  logic [11:0] result_i = '0;
  logic        sclk_i = 1'b0;
  wire         sdata_o;
  logic        sdata_oe_o, busy_o, hold_o, sleep_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  sar_seq_top #(.FAST_CYC(FAST), .SLEEP_CYC(SLEEP), .WAKE_CYC(WAKE)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_sleep_i(mode_sleep_i), .conv_n_i(conv_n_i),
    .result_i(result_i), .sclk_i(sclk_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .busy_o(busy_o), .hold_o(hold_o), .sleep_o(sleep_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, one step per clock
  bit          m_busy, m_hold, m_smode, m_oe, m_bit, m_cp, m_sp;
  int          m_tmr, m_len, m_cnt;
  logic [11:0] m_res;
  logic [15:0] m_frame;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_hold = 0; m_smode = 0; m_oe = 0; m_bit = 0;
      m_cp = 1; m_sp = 0; m_tmr = 0; m_len = 0; m_cnt = 0;
      m_res = '0; m_frame = '0;
    end else begin
      bit cf, cr, sr, sf;
      cf = m_cp && !conv_n_i;
      cr = !m_cp && conv_n_i;
      sr = !m_sp && sclk_i;
      sf = m_sp && !sclk_i;
      if (cf) begin
        m_cnt = 0; m_oe = 0;
      end else if (sr) begin
        if (m_cnt == 0) m_frame = {4'b0000, m_res};
        m_bit = m_frame[15 - m_cnt];
        m_cnt++;
        m_oe = 1;
      end else if (sf && m_cnt == 16) begin
        m_cnt = 0; m_oe = 0;
      end
      if (m_busy) begin
        m_tmr++;
        if (m_smode && m_tmr == WAKE) m_hold = 1;
        if (m_tmr == m_len) begin
          m_busy = 0; m_hold = 0; m_res = result_i;
        end
      end else if (!mode_sleep_i && cf) begin
        m_busy = 1; m_hold = 1; m_tmr = 0; m_len = FAST; m_smode = 0;
      end else if (mode_sleep_i && cr) begin
        m_busy = 1; m_hold = 0; m_tmr = 0; m_len = SLEEP; m_smode = 1;
      end
      m_cp = conv_n_i;
      m_sp = sclk_i;
    end
  end

  int busy_cnt = 0;
  int wake_cnt = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(busy_o == m_busy, "R2 busy", busy_o, m_busy);
      chk(hold_o == m_hold, "R3 hold", hold_o, m_hold);
      chk(sleep_o == (mode_sleep_i && !m_busy), "R3 sleep", sleep_o, mode_sleep_i && !m_busy);
      chk(sdata_oe_o == m_oe, "R6 oe", sdata_oe_o, m_oe);
      if (m_oe) chk(sdata_o == m_bit, "R5 data", sdata_o, m_bit);
      if (busy_o) busy_cnt++;
      if (busy_o && !hold_o) wake_cnt++;
    end
  end

  task automatic conv_pulse();
    @(negedge clk_i) conv_n_i = 1'b0;
    @(negedge clk_i) conv_n_i = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic read_bits(input int n, output logic [31:0] val);
    val = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) sclk_i = 1'b1;
      @(negedge clk_i);
      val = {val[30:0], sdata_o};
      sclk_i = 1'b0;
    end
    @(negedge clk_i);
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(hold_o == 0, "R1 hold", hold_o, 0);
    chk(sdata_oe_o == 0, "R1 oe", sdata_oe_o, 0);
    chk(sleep_o == 0, "R1 sleep", sleep_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 fast conversion, R4 capture, R5 frame, R6 release
    result_i = 12'hA5C;
    busy_cnt = 0;
    conv_pulse();
    chk(busy_o && hold_o, "R2 start", {busy_o, hold_o}, 2'b11);
    wait_idle();
    chk(busy_cnt == FAST, "R2 length", busy_cnt, FAST);
    result_i = 12'h111;
    read_bits(16, rd);
    chk(rd[15:0] == 16'h0A5C, "R5 frame", rd[15:0], 16'h0A5C);
    chk(sdata_oe_o == 0, "R6 released", sdata_oe_o, 0);

    // R10 extremes
    result_i = 12'hFFF;
    conv_pulse(); wait_idle();
    read_bits(16, rd);
    chk(rd[15:0] == 16'h0FFF, "R10 ones", rd[15:0], 16'h0FFF);
    result_i = 12'h000;
    conv_pulse(); wait_idle();
    read_bits(16, rd);
    chk(rd[15:0] == 16'h0000, "R10 zeros", rd[15:0], 16'h0000);

    // R9 start edge during busy
    result_i = 12'h6B2;
    busy_cnt = 0;
    conv_pulse();
    @(negedge clk_i);
    conv_pulse();
    wait_idle();
    chk(busy_cnt == FAST, "R9 length", busy_cnt, FAST);

    // R7 continuous clocks
    read_bits(32, rd);
    chk(rd == 32'h06B2_06B2, "R7 wrap", rd, 32'h06B2_06B2);

    // R8 clear mid frame, then read during conversion
    read_bits(5, rd);
    chk(sdata_oe_o == 1, "R8 mid frame", sdata_oe_o, 1);
    result_i = 12'h2D4;
    conv_pulse();
    chk(sdata_oe_o == 0, "R8 cleared", sdata_oe_o, 0);
    read_bits(16, rd);
    chk(rd[15:0] == 16'h06B2, "R8 restart", rd[15:0], 16'h06B2);
    wait_idle();

    // R8 clear and sclk rise in the same cycle
    read_bits(3, rd);
    @(negedge clk_i) begin conv_n_i = 1'b0; sclk_i = 1'b1; end
    @(negedge clk_i);
    chk(sdata_oe_o == 0, "R8 same cycle", sdata_oe_o, 0);
    conv_n_i = 1'b1; sclk_i = 1'b0;
    wait_idle();
    read_bits(16, rd);
    chk(rd[15:0] == 16'h02D4, "R8 after tie", rd[15:0], 16'h02D4);

    // R3 auto-sleep conversion
    mode_sleep_i = 1'b1;
    @(negedge clk_i);
    chk(sleep_o == 1, "R3 asleep", sleep_o, 1);
    result_i = 12'h3C7;
    busy_cnt = 0; wake_cnt = 0;
    conv_pulse();
    @(negedge clk_i);
    chk(busy_o && !hold_o && !sleep_o, "R3 wake", {busy_o, hold_o, sleep_o}, 3'b100);
    wait_idle();
    chk(busy_cnt == SLEEP, "R3 length", busy_cnt, SLEEP);
    chk(wake_cnt == WAKE, "R3 wake lag", wake_cnt, WAKE);
    chk(sleep_o == 1, "R3 back asleep", sleep_o, 1);
    read_bits(16, rd);
    chk(rd[15:0] == 16'h03C7, "R4 sleep result", rd[15:0], 16'h03C7);

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule